// File: doc/BRIEF.md
# Request-Acknowledge Timing Monitor

This block is a synthesizable protocol watcher for a one-bit request and a one-bit acknowledge that share a single clock. Each clock edge on which the request is sampled high opens its own check. The check ends with a pass or a fail according to the selected rule. Because every request gets its own check, requests that overlap are judged separately.

Two rules are available. In the window rule, an acknowledge seen on any of the first three edges after the request closes the check as a pass. A single acknowledge closes every open check whose window it falls in. In the pulse rule, the acknowledge must rise on exactly the second edge after the request and must be low again on the third edge.

The block reports results on two registered one-cycle flags, one for pass and one for fail. It also keeps two saturating totals. A synchronous enable switches the block on. Dropping the enable discards every open check, so reset periods and power-down periods produce no false failures.

Top module: `hs_timing_mon`

## Requirements
- R1: While `rst` is sampled high, all outputs are 0 on the next cycle: `pass_pulse`, `fail_pulse`, `pass_count` and `fail_count`.
- R2: Window rule (`rule_sel` = 0). An edge with `req` high and `en` high opens a check. If `ack` is sampled high on the 1st, 2nd or 3rd later edge, the check passes at the first such edge. `pass_pulse` is then high for the cycle after that edge, and `pass_count` has grown by one.
- R3: Window rule. A check that sees `ack` low on all three of its edges fails at the 3rd edge. `fail_pulse` is then high for the cycle after that edge, and `fail_count` has grown by one. An edge with `ack` high never produces a fail in this rule.
- R4: An edge with `req` sampled low opens no check. Changes on `ack` with no open check never produce a pass or a fail.
- R5: Checks from requests on consecutive edges are tracked independently. One `ack` edge passes every open check that is inside its window.
- R6: Pulse rule (`rule_sel` = 1). A check passes at the 3rd edge after its request under three conditions: `ack` is low at edge 1, high at edge 2 and low at edge 3.
- R7: Pulse rule. A check fails at edge 2 unless `ack` rose there (low at edge 1, high at edge 2). A check that reached edge 3 fails if `ack` is still high there.
- R8: When several checks resolve on the same edge, each resolution is added to its total. The pulse output for that edge is still a single one-cycle high.
- R9: `pass_count` and `fail_count` are CNT_W bits wide, 8 by default. Each stops at its all-ones value (255) and holds there.
- R10: An edge with `en` sampled low discards all open checks, opens none and resolves none. `rule_sel` may change only while `en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Monitor enable; low discards open checks |
| rule_sel | input | 1 | 0 selects the window rule, 1 selects the pulse rule |
| req | input | 1 | Observed request |
| ack | input | 1 | Observed acknowledge |
| pass_pulse | output | 1 | High for one cycle after an edge on which at least one check passed |
| fail_pulse | output | 1 | High for one cycle after an edge on which at least one check failed |
| pass_count | output | CNT_W | Saturating total of passed checks |
| fail_count | output | CNT_W | Saturating total of failed checks |

## Verification
The hardest case to reach from the ports is two failures on one edge, because the window rule can fail only its oldest check on any edge. The bench reaches it in the pulse rule. It issues requests on two consecutive edges and then holds `ack` high for two edges. The older check then sees a wide pulse at the same edge where the younger check sees no rising edge, so `fail_count` must grow by two while `fail_pulse` is high for only one cycle. Saturation is reached with long streams of back-to-back requests in each rule direction.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic {
    RULE_WINDOW = 1'b0,
    RULE_PULSE  = 1'b1
  } rule_e;
endpackage

// File: rtl/hs_age_track.sv
// Pending-check age pipeline. Bit j of age_q marks a check opened j+1 edges ago.
module hs_age_track
  import hs_pkg::*;
#(
  parameter int WIN_MIN   = 1,
  parameter int WIN_MAX   = 3,
  parameter int PULSE_LAG = 2,
  parameter int DEPTH     = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  rule_e            rule,
  input  logic             req,
  input  logic             ack,
  output logic [DEPTH-1:0] pass_hit,
  output logic [DEPTH-1:0] fail_hit
);
  logic [DEPTH-1:0] age_q;
  logic [DEPTH-2:0] keep;
  logic             ack_prev_q;
  logic             ack_rise;
  logic             win_rule;

  assign ack_rise = ack && !ack_prev_q;
  assign win_rule = (rule == RULE_WINDOW);

  for (genvar j = 0; j < DEPTH; j++) begin : g_slot
    localparam int  AGE      = j + 1;
    localparam bit  IN_WIN   = (AGE >= WIN_MIN) && (AGE <= WIN_MAX);
    localparam bit  WIN_LAST = (AGE == WIN_MAX);
    localparam bit  P_EARLY  = (AGE < PULSE_LAG);
    localparam bit  P_RISE   = (AGE == PULSE_LAG);
    localparam bit  P_HOLD   = (AGE == PULSE_LAG + 1);
    logic live;
    assign live = en && age_q[j];
    assign pass_hit[j] = live && (win_rule ? (IN_WIN && ack) : (P_HOLD && !ack));
    assign fail_hit[j] = live && (win_rule ? (WIN_LAST && !ack)
                                           : ((P_RISE && !ack_rise) || (P_HOLD && ack)));
    if (j < DEPTH - 1) begin : g_fwd
      assign keep[j] = live && !pass_hit[j] && !fail_hit[j] &&
                       (win_rule ? (AGE < WIN_MAX) : (P_EARLY || P_RISE));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      age_q      <= '0;
      ack_prev_q <= 1'b0;
    end else begin
      ack_prev_q <= ack;
      if (!en) age_q <= '0;
      else     age_q <= {keep, req};
    end
  end
endmodule

// File: rtl/hs_sat_count.sv
// Adds the number of set bits in hits to a saturating total; flags any hit.
module hs_sat_count #(
  parameter int N = 3,
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] hits,
  output logic [W-1:0] count,
  output logic         any_q
);
  localparam int SW = W + $clog2(N + 1);
  localparam logic [W-1:0] TOP = '1;
  logic [SW-1:0] sum;

  always_comb sum = SW'(count) + SW'($countones(hits));

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      any_q <= 1'b0;
    end else begin
      count <= (sum > {{(SW-W){1'b0}}, TOP}) ? TOP : sum[W-1:0];
      any_q <= |hits;
    end
  end
endmodule

// File: rtl/hs_timing_mon.sv
module hs_timing_mon
  import hs_pkg::*;
#(
  parameter int WIN_MIN   = 1,
  parameter int WIN_MAX   = 3,
  parameter int PULSE_LAG = 2,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             rule_sel,
  input  logic             req,
  input  logic             ack,
  output logic             pass_pulse,
  output logic             fail_pulse,
  output logic [CNT_W-1:0] pass_count,
  output logic [CNT_W-1:0] fail_count
);
  localparam int DEPTH = (WIN_MAX > PULSE_LAG + 1) ? WIN_MAX : PULSE_LAG + 1;

  logic [DEPTH-1:0] pass_hit;
  logic [DEPTH-1:0] fail_hit;
  rule_e            rule;

  assign rule = rule_e'(rule_sel);

  hs_age_track #(
    .WIN_MIN(WIN_MIN), .WIN_MAX(WIN_MAX), .PULSE_LAG(PULSE_LAG), .DEPTH(DEPTH)
  ) u_track (
    .clk(clk), .rst(rst), .en(en), .rule(rule), .req(req), .ack(ack),
    .pass_hit(pass_hit), .fail_hit(fail_hit)
  );

  hs_sat_count #(.N(DEPTH), .W(CNT_W)) u_pass_cnt (
    .clk(clk), .rst(rst), .hits(pass_hit), .count(pass_count), .any_q(pass_pulse)
  );

  hs_sat_count #(.N(DEPTH), .W(CNT_W)) u_fail_cnt (
    .clk(clk), .rst(rst), .hits(fail_hit), .count(fail_count), .any_q(fail_pulse)
  );
endmodule

// File: rtl/hs_timing_mon_chk.sv
module hs_timing_mon_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             rule_sel,
  input logic             ack,
  input logic             pass_pulse,
  input logic             fail_pulse,
  input logic [CNT_W-1:0] pass_count,
  input logic [CNT_W-1:0] fail_count
);
  localparam logic [CNT_W-1:0] TOP = '1;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!pass_pulse && !fail_pulse && pass_count == '0 && fail_count == '0)); // R1

  AST_PASS_COUNT_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (pass_count != $past(pass_count)) |-> pass_pulse); // R2

  AST_WIN_ACK_NO_FAIL: assert property (@(posedge clk) disable iff (rst)
    (en && !rule_sel && ack) |=> !fail_pulse); // R3

  AST_FAIL_COUNT_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (fail_count != $past(fail_count)) |-> fail_pulse); // R8

  AST_PASS_SATURATES: assert property (@(posedge clk) disable iff (rst)
    (pass_count == TOP) |=> (pass_count == TOP)); // R9

  AST_FAIL_SATURATES: assert property (@(posedge clk) disable iff (rst)
    (fail_count == TOP) |=> (fail_count == TOP)); // R9

  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!pass_pulse && !fail_pulse)); // R10

  AST_RULE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en)) |-> $stable(rule_sel)); // R10
endmodule

bind hs_timing_mon hs_timing_mon_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .rule_sel(rule_sel), .ack(ack),
  .pass_pulse(pass_pulse), .fail_pulse(fail_pulse),
  .pass_count(pass_count), .fail_count(fail_count)
);

// File: tb/tb_hs_timing_mon.sv
`timescale 1ns/1ps
module tb_hs_timing_mon;
  localparam int WMIN = 1;
  localparam int WMAX = 3;
  localparam int LAG  = 2;
  localparam int CW   = 8;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst, en, rule_sel, req, ack;
  logic pass_pulse, fail_pulse;
  logic [CW-1:0] pass_count, fail_count;

  always #2.5 clk = ~clk;

  hs_timing_mon #(.WIN_MIN(WMIN), .WIN_MAX(WMAX), .PULSE_LAG(LAG), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .en(en), .rule_sel(rule_sel), .req(req), .ack(ack),
    .pass_pulse(pass_pulse), .fail_pulse(fail_pulse),
    .pass_count(pass_count), .fail_count(fail_count)
  );

  typedef struct {
    bit    p;
    bit    f;
    int    pc;
    int    fc;
    string tag;
  } exp_t;

  exp_t sbq[$];
  int   open_s[$];
  int   edge_n, exp_pc, exp_fc;
  bit   prev_ack;
  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;

  // Reference model: evaluates every open check against one sampled edge.
  task automatic model_edge(input bit e, input bit m, input bit r, input bit a, input string tag);
    int keep_q[$];
    int np = 0;
    int nf = 0;
    exp_t it;
    if (e) begin
      foreach (open_s[i]) begin
        int age = edge_n - open_s[i];
        if (!m) begin
          if (a && age >= WMIN && age <= WMAX) np++;
          else if (age >= WMAX) nf++;
          else keep_q.push_back(open_s[i]);
        end else begin
          if (age < LAG) keep_q.push_back(open_s[i]);
          else if (age == LAG) begin
            if (a && !prev_ack) keep_q.push_back(open_s[i]);
            else nf++;
          end else begin
            if (a) nf++;
            else np++;
          end
        end
      end
      if (r) keep_q.push_back(edge_n);
    end
    open_s = keep_q;
    prev_ack = a;
    edge_n++;
    exp_pc = (exp_pc + np > MAXC) ? MAXC : exp_pc + np;
    exp_fc = (exp_fc + nf > MAXC) ? MAXC : exp_fc + nf;
    it.p = (np > 0); it.f = (nf > 0); it.pc = exp_pc; it.fc = exp_fc; it.tag = tag;
    sbq.push_back(it);
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected result.
  task automatic step(input bit e, input bit m, input bit r, input bit a, input string tag);
    @(negedge clk);
    en = e; rule_sel = m; req = r; ack = a;
    @(posedge clk);
    model_edge(e, m, r, a, tag);
  endtask

  task automatic idle(input int n, input bit m, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, m, 1'b0, 1'b0, tag);
  endtask

  // Monitor: compares the registered outputs after each edge.
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      exp_t it;
      it = sbq.pop_front();
      checks++;
      if (pass_pulse !== it.p || fail_pulse !== it.f ||
          pass_count !== CW'(it.pc) || fail_count !== CW'(it.fc)) begin
        failures++;
        $display("FAIL %s: got p=%0b f=%0b pc=%0d fc=%0d, expected p=%0b f=%0b pc=%0d fc=%0d",
                 it.tag, pass_pulse, fail_pulse, pass_count, fail_count,
                 it.p, it.f, it.pc, it.fc);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got no end of run, expected end of run");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; en = 1'b0; rule_sel = 1'b0; req = 1'b0; ack = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if (pass_pulse !== 1'b0 || fail_pulse !== 1'b0 || pass_count !== '0 || fail_count !== '0) begin
      failures++;
      $display("FAIL R1: got p=%0b f=%0b pc=%0d fc=%0d, expected all 0",
               pass_pulse, fail_pulse, pass_count, fail_count);
    end
    rst = 1'b0;
    edge_n = 0; exp_pc = 0; exp_fc = 0; prev_ack = 1'b0;

    // R2: ack on the 1st, 2nd and 3rd edge after the request
    step(1, 0, 1, 0, "R2"); step(1, 0, 0, 1, "R2"); idle(3, 0, "R2");
    step(1, 0, 1, 0, "R2"); step(1, 0, 0, 0, "R2"); step(1, 0, 0, 1, "R2"); idle(3, 0, "R2");
    step(1, 0, 1, 0, "R2"); idle(2, 0, "R2"); step(1, 0, 0, 1, "R2"); idle(3, 0, "R2");
    // R3: no ack in the window, and a late ack does not help
    step(1, 0, 1, 0, "R3"); idle(3, 0, "R3"); step(1, 0, 0, 1, "R3"); idle(2, 0, "R3");
    // R4: ack activity with no request
    step(1, 0, 0, 1, "R4"); step(1, 0, 0, 0, "R4"); step(1, 0, 0, 1, "R4"); step(1, 0, 0, 1, "R4");
    idle(3, 0, "R4");
    // R5/R8: three overlapping requests retired by one ack
    step(1, 0, 1, 0, "R5"); step(1, 0, 1, 0, "R5"); step(1, 0, 1, 0, "R5");
    step(1, 0, 0, 1, "R5 R8"); idle(3, 0, "R5");
    // R5: a held request with no ack fails once per edge
    for (int i = 0; i < 4; i++) step(1, 0, 1, 0, "R5");
    idle(4, 0, "R5");
    // R10: disabling discards open checks; the rule changes only while disabled
    step(1, 0, 1, 0, "R10"); step(1, 0, 1, 0, "R10");
    step(0, 0, 0, 0, "R10"); step(0, 1, 1, 0, "R10");
    idle(4, 1, "R10");
    // R6: correct pulse
    step(1, 1, 1, 0, "R6"); step(1, 1, 0, 0, "R6"); step(1, 1, 0, 1, "R6"); step(1, 1, 0, 0, "R6");
    idle(2, 1, "R6");
    // R7: late rise fails at edge 2
    step(1, 1, 1, 0, "R7"); step(1, 1, 0, 0, "R7"); step(1, 1, 0, 0, "R7"); step(1, 1, 0, 1, "R7");
    idle(3, 1, "R7");
    // R7: wide pulse fails at edge 3
    step(1, 1, 1, 0, "R7"); step(1, 1, 0, 0, "R7"); step(1, 1, 0, 1, "R7"); step(1, 1, 0, 1, "R7");
    idle(3, 1, "R7");
    // R7: ack already high at edge 1, so no rise at edge 2
    step(1, 1, 1, 0, "R7"); step(1, 1, 0, 1, "R7"); step(1, 1, 0, 1, "R7"); idle(3, 1, "R7");
    // R8: two failures on one edge in pulse rule
    step(1, 1, 1, 0, "R8"); step(1, 1, 1, 0, "R8"); step(1, 1, 0, 1, "R8"); step(1, 1, 0, 1, "R8");
    idle(4, 1, "R8");
    // R9: saturate both totals in window rule
    step(0, 0, 0, 0, "R9");
    for (int i = 0; i < 270; i++) step(1, 0, 1, 0, "R9");
    idle(4, 0, "R9");
    for (int i = 0; i < 270; i++) step(1, 0, 1, 1, "R9");
    idle(4, 0, "R9");

    @(negedge clk);
    #1;
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule